// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the command front end of a NOR-style flash array. The host bus issues single-cycle writes and reads, each with an address and a data word. A write in the idle state is decoded as a command from its low data byte. The buffered-program command is a multi-write transaction with four parts: an opening command names the target block, the next write gives the number of words, the data words are collected in a small write buffer, and a closing command starts the array program.

Programming is handled by a behavioural engine. It copies one buffered word per cycle into a register-based array and holds the array busy for a modelled time. That time doubles when the data range crosses a buffer-sized window. While the engine runs, the sequencer accepts only read-mode commands and a suspend request. Every other command is ignored.

The block keeps a status byte with three bits: ready, suspended and a sticky program error. A read-mode register selects what host reads return: array words, an identifier, a query code or the status byte. Reads of the partition being programmed return a marker word instead of stale data.

Top module: `fbp_cmd_seq`

## Requirements
- R1: After reset, reads return the status byte 0x0080 (bit 7 = ready, bit 6 = suspended, bit 4 = program error, other bits 0), and every array word reads 0xFFFF once array mode is selected.
- R2: Commands are decoded from wdata[7:0]: 0xE8 open program, 0xD0 confirm/resume, 0xFF array mode, 0x90 identifier mode (0x00A5), 0x98 query mode (0x0051), 0x70 status mode, 0x50 clear status, 0xB0 suspend. A completed program stores data word i at block offset (first data address + i) modulo 64, in the block of the opening write.
- R3: The write after 0xE8 is the word count. A count of 0 or above 32 aborts. After exactly that many data writes, the next write must be 0xD0, or the operation aborts. Every abort sets bit 4 and returns to idle without changing the array. A count of 32 is accepted.
- R4: During the count, data and confirm writes, a write whose address lies outside the 64-word block of the opening write aborts the operation (bit 4 set, array unchanged).
- R5: Reads are served at any time and never alter the sequence. After 0xE8 the read mode is status.
- R6: 0xD0 selects status mode and clears bit 7 for exactly 40 cycles. The time is 80 cycles when (first data offset mod 32) + count exceeds 32. Reads issued on the following cycles see bit 7 = 0 that many times.
- R7: Bit 4 stays set across later operations until 0x50 is written while the array is not busy or suspended.
- R8: While busy, only 0xFF, 0x90, 0x98, 0x70 and 0xB0 take effect. In particular, 0x50 leaves bit 4 set.
- R9: While a program is busy or suspended, array, identifier and query reads whose address partition (address bit 7) matches the block being programmed return 0xDEAD. Reads of the other partition return normal data, and array data reads correctly after completion.
- R10: 0xB0 while busy freezes the busy time and makes the status 0x00C0. 0xD0 resumes, and the remaining busy time continues from where it stopped.
- R11: Every read returns its data with rvalid exactly one cycle after rd_en, and rvalid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host bus write strobe |
| rd_en | input | 1 | Host bus read strobe |
| addr | input | AW (8) | Word address of the bus cycle |
| wdata | input | DW (16) | Write data, command byte in bits 7:0 |
| rdata | output | DW (16) | Read result |
| rvalid | output | 1 | Read result valid, one cycle after rd_en |

## Verification
A read result lands on the cycle after rd_en. The monitor therefore samples five nanoseconds after each rising edge and matches results against a queue that the read driver fills in issue order. A write changes status and mode in time for a read issued on the very next cycle. For that reason the busy-time checks hold rd_en high from the cycle after the confirming write and count reads with bit 7 clear: 40 for an aligned range, 80 for a range that crosses a window, and 39 after a suspend that came one cycle in. Checks of commands the block must ignore are made after the busy period ends, through the status byte and array reads.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CNT,
      S_FILL,
      S_CONF,
      S_BUSY,
      S_SUSP
   } seq_state_e;

   typedef enum logic [1:0] {
      RM_ARRAY,
      RM_ID,
      RM_CFI,
      RM_STATUS
   } rd_mode_e;

   localparam logic [7:0] OP_SETUP    = 8'hE8;
   localparam logic [7:0] OP_CONFIRM  = 8'hD0;
   localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
   localparam logic [7:0] OP_RD_ID    = 8'h90;
   localparam logic [7:0] OP_RD_CFI   = 8'h98;
   localparam logic [7:0] OP_RD_STAT  = 8'h70;
   localparam logic [7:0] OP_CLR_STAT = 8'h50;
   localparam logic [7:0] OP_SUSPEND  = 8'hB0;

   localparam int SR_READY = 7;
   localparam int SR_SUSP  = 6;
   localparam int SR_PERR  = 4;

   function automatic logic is_read_op(input logic [7:0] op);
      return (op == OP_RD_ARRAY) || (op == OP_RD_ID) ||
             (op == OP_RD_CFI) || (op == OP_RD_STAT);
   endfunction

   function automatic rd_mode_e op_to_mode(input logic [7:0] op);
      case (op)
         OP_RD_ARRAY: return RM_ARRAY;
         OP_RD_ID:    return RM_ID;
         OP_RD_CFI:   return RM_CFI;
         default:     return RM_STATUS;
      endcase
   endfunction

endpackage

// File: rtl/fbp_regfile.sv
// Generic register-per-word storage with one write and one read port.
module fbp_regfile #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   parameter logic [DW-1:0] RST_VAL = '0,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   if (DEPTH < 2) begin : g_chk_depth
      $error("fbp_regfile: DEPTH must be at least 2");
   end
   if ((1 << IW) != DEPTH) begin : g_chk_pow2
      $error("fbp_regfile: DEPTH must be a power of two");
   end

   logic [DW-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= RST_VAL;
         end else if (we && (waddr == IW'(g))) begin
            cell_q <= wdata;
         end
      end
      assign words[g] = cell_q;
   end

   assign rdata = words[raddr];

endmodule

// File: rtl/fbp_prog_engine.sv
// Behavioural array-program engine: copies one word per running cycle
// and stays busy for a modelled time, doubled on a window crossing.
module fbp_prog_engine #(
   parameter int BUF_WORDS     = 32,
   parameter int PROG_CYCLES   = 40,
   parameter bit CROSS_PENALTY = 1'b1,
   localparam int CW = $clog2(BUF_WORDS + 1),
   localparam int IW = $clog2(BUF_WORDS),
   localparam int TW = $clog2(2 * PROG_CYCLES + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          run,
   input  logic          crosses,
   input  logic [CW-1:0] nwords,
   output logic          done,
   output logic          wr,
   output logic [IW-1:0] widx,
   output logic [TW-1:0] tick
);

   if (PROG_CYCLES < BUF_WORDS) begin : g_chk_time
      $error("fbp_prog_engine: PROG_CYCLES must cover one word per cycle");
   end

   logic          active_q;
   logic [TW-1:0] tick_q;
   logic [TW-1:0] limit_q;
   logic [TW-1:0] limit_d;
   logic [CW-1:0] idx_q;
   logic [CW-1:0] nw_q;

   if (CROSS_PENALTY) begin : g_penalty
      assign limit_d = crosses ? TW'(2 * PROG_CYCLES) : TW'(PROG_CYCLES);
   end else begin : g_flat
      logic unused_cross;
      assign unused_cross = crosses;
      assign limit_d = TW'(PROG_CYCLES);
   end

   assign wr   = active_q && run && (idx_q < nw_q);
   assign done = active_q && run && (tick_q == limit_q - TW'(1));
   assign widx = idx_q[IW-1:0];
   assign tick = tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         tick_q   <= '0;
         limit_q  <= '0;
         idx_q    <= '0;
         nw_q     <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         tick_q   <= '0;
         limit_q  <= limit_d;
         idx_q    <= '0;
         nw_q     <= nwords;
      end else if (active_q && run) begin
         tick_q <= tick_q + TW'(1);
         if (wr) idx_q <= idx_q + CW'(1);
         if (done) active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/fbp_cmd_seq.sv
module fbp_cmd_seq
   import fbp_pkg::*;
#(
   parameter int DW            = 16,
   parameter int AW            = 8,
   parameter int BLK_AW        = 6,
   parameter int PART_BITS     = 1,
   parameter int BUF_WORDS     = 32,
   parameter int PROG_CYCLES   = 40,
   parameter bit CROSS_PENALTY = 1'b1,
   parameter logic [DW-1:0] ID_CODE  = 'h00A5,
   parameter logic [DW-1:0] CFI_CODE = 'h0051,
   parameter logic [DW-1:0] INV_WORD = 'hDEAD
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   localparam int BLK_W  = AW - BLK_AW;
   localparam int BUF_IW = $clog2(BUF_WORDS);
   localparam int CW     = $clog2(BUF_WORDS + 1);
   localparam int TW     = $clog2(2 * PROG_CYCLES + 1);
   localparam int ADEPTH = 1 << AW;

   if (DW < 8) begin : g_chk_dw
      $error("fbp_cmd_seq: DW must hold a command byte");
   end
   if (BLK_AW < BUF_IW || BLK_W < 1) begin : g_chk_blk
      $error("fbp_cmd_seq: block must hold the buffer and leave a block index");
   end
   if (PART_BITS < 1 || PART_BITS > BLK_W) begin : g_chk_part
      $error("fbp_cmd_seq: PART_BITS out of range");
   end
   if ((1 << BUF_IW) != BUF_WORDS) begin : g_chk_buf
      $error("fbp_cmd_seq: BUF_WORDS must be a power of two");
   end

   // ---------------- sequencer state ----------------
   seq_state_e        state_q;
   rd_mode_e          rmode_q;
   logic [BLK_W-1:0]  blk_q;
   logic [CW-1:0]     nwords_q;
   logic [CW-1:0]     fill_q;
   logic [BLK_AW-1:0] start_off_q;
   logic              err_q;
   logic [DW-1:0]     rdata_q;
   logic              rvalid_q;

   // ---------------- decode ----------------
   logic [7:0]       op;
   logic [BLK_W-1:0] wblk;
   logic             same_blk;
   logic             cnt_ok;
   logic             start_prog;
   logic [CW:0]      span;
   logic             crosses;

   assign op       = wdata[7:0];
   assign wblk     = addr[AW-1:BLK_AW];
   assign same_blk = (wblk == blk_q);
   assign cnt_ok   = (wdata != '0) && (wdata <= DW'(BUF_WORDS));
   assign start_prog = wr_en && (state_q == S_CONF) && same_blk && (op == OP_CONFIRM);
   assign span     = (CW+1)'(start_off_q[BUF_IW-1:0]) + (CW+1)'(nwords_q);
   assign crosses  = span > (CW+1)'(BUF_WORDS);

   // ---------------- engine, buffer, array ----------------
   logic              eng_done;
   logic              eng_wr;
   logic [BUF_IW-1:0] eng_widx;
   logic [TW-1:0]     eng_tick;
   logic [DW-1:0]     buf_rdata;
   logic [DW-1:0]     arr_rdata;
   logic              buf_we;
   logic [AW-1:0]     arr_waddr;

   assign buf_we    = wr_en && (state_q == S_FILL) && same_blk;
   assign arr_waddr = {blk_q, start_off_q + BLK_AW'(eng_widx)};

   fbp_prog_engine #(
      .BUF_WORDS     (BUF_WORDS),
      .PROG_CYCLES   (PROG_CYCLES),
      .CROSS_PENALTY (CROSS_PENALTY)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_prog),
      .run     (state_q == S_BUSY),
      .crosses (crosses),
      .nwords  (nwords_q),
      .done    (eng_done),
      .wr      (eng_wr),
      .widx    (eng_widx),
      .tick    (eng_tick)
   );

   fbp_regfile #(
      .DW      (DW),
      .DEPTH   (BUF_WORDS),
      .RST_VAL ('0)
   ) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (buf_we),
      .waddr (fill_q[BUF_IW-1:0]),
      .wdata (wdata),
      .raddr (eng_widx),
      .rdata (buf_rdata)
   );

   fbp_regfile #(
      .DW      (DW),
      .DEPTH   (ADEPTH),
      .RST_VAL ('1)
   ) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (eng_wr),
      .waddr (arr_waddr),
      .wdata (buf_rdata),
      .raddr (addr),
      .rdata (arr_rdata)
   );

   // ---------------- command state machine ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         rmode_q     <= RM_STATUS;
         blk_q       <= '0;
         nwords_q    <= '0;
         fill_q      <= '0;
         start_off_q <= '0;
         err_q       <= 1'b0;
      end else begin
         if (wr_en) begin
            unique case (state_q)
               S_IDLE: begin
                  if (op == OP_SETUP) begin
                     blk_q   <= wblk;
                     state_q <= S_CNT;
                     rmode_q <= RM_STATUS;
                  end else if (is_read_op(op)) begin
                     rmode_q <= op_to_mode(op);
                  end else if (op == OP_CLR_STAT) begin
                     err_q <= 1'b0;
                  end
               end
               S_CNT: begin
                  if (!same_blk || !cnt_ok) begin
                     state_q <= S_IDLE;
                     err_q   <= 1'b1;
                  end else begin
                     nwords_q <= wdata[CW-1:0];
                     fill_q   <= '0;
                     state_q  <= S_FILL;
                  end
               end
               S_FILL: begin
                  if (!same_blk) begin
                     state_q <= S_IDLE;
                     err_q   <= 1'b1;
                  end else begin
                     if (fill_q == '0) start_off_q <= addr[BLK_AW-1:0];
                     fill_q <= fill_q + CW'(1);
                     if (fill_q + CW'(1) == nwords_q) state_q <= S_CONF;
                  end
               end
               S_CONF: begin
                  if (start_prog) begin
                     state_q <= S_BUSY;
                     rmode_q <= RM_STATUS;
                  end else begin
                     state_q <= S_IDLE;
                     err_q   <= 1'b1;
                  end
               end
               S_BUSY: begin
                  if (is_read_op(op)) rmode_q <= op_to_mode(op);
                  else if (op == OP_SUSPEND) state_q <= S_SUSP;
               end
               S_SUSP: begin
                  if (is_read_op(op)) rmode_q <= op_to_mode(op);
                  else if (op == OP_CONFIRM) state_q <= S_BUSY;
               end
               default: state_q <= S_IDLE;
            endcase
         end
         if (state_q == S_BUSY && eng_done) state_q <= S_IDLE;
      end
   end

   // ---------------- read path ----------------
   logic [7:0] sr;
   logic       in_prog;
   logic       hit_busy_part;

   always_comb begin
      sr           = '0;
      sr[SR_READY] = (state_q != S_BUSY);
      sr[SR_SUSP]  = (state_q == S_SUSP);
      sr[SR_PERR]  = err_q;
   end

   assign in_prog       = (state_q == S_BUSY) || (state_q == S_SUSP);
   assign hit_busy_part = in_prog &&
                          (addr[AW-1 -: PART_BITS] == blk_q[BLK_W-1 -: PART_BITS]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_en;
         if (rd_en) begin
            unique case (rmode_q)
               RM_STATUS: rdata_q <= DW'(sr);
               RM_ARRAY:  rdata_q <= hit_busy_part ? INV_WORD : arr_rdata;
               RM_ID:     rdata_q <= hit_busy_part ? INV_WORD : ID_CODE;
               RM_CFI:    rdata_q <= hit_busy_part ? INV_WORD : CFI_CODE;
               default:   rdata_q <= '0;
            endcase
         end
      end
   end

   assign rdata  = rdata_q;
   assign rvalid = rvalid_q;

endmodule

// File: rtl/fbp_cmd_seq_chk.sv
module fbp_cmd_seq_chk
   import fbp_pkg::*;
#(
   parameter int DW          = 16,
   parameter int AW          = 8,
   parameter int BLK_AW      = 6,
   parameter int PART_BITS   = 1,
   parameter int BUF_WORDS   = 32,
   parameter int PROG_CYCLES = 40,
   parameter logic [DW-1:0] INV_WORD = 'hDEAD,
   localparam int BLK_W = AW - BLK_AW,
   localparam int TW    = $clog2(2 * PROG_CYCLES + 1)
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [AW-1:0]    addr,
   input logic [DW-1:0]    wdata,
   input logic [DW-1:0]    rdata,
   input logic             rvalid,
   input seq_state_e       state,
   input rd_mode_e         rmode,
   input logic [BLK_W-1:0] blk,
   input logic             err,
   input logic [TW-1:0]    tick
);

   logic in_txn;
   logic off_blk;
   logic part_hit;

   assign in_txn   = (state == S_CNT) || (state == S_FILL) || (state == S_CONF);
   assign off_blk  = addr[AW-1:BLK_AW] != blk;
   assign part_hit = addr[AW-1 -: PART_BITS] == blk[BLK_W-1 -: PART_BITS];

   p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);

   p_no_stray_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid);

   p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && state == S_CNT && (wdata == '0 || wdata > DW'(BUF_WORDS)))
      |=> (state == S_IDLE && err));

   p_block_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_txn && off_blk) |=> (state == S_IDLE && err));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(wr_en && state == S_IDLE && wdata[7:0] == OP_CLR_STAT)) |=> err);

   p_busy_keeps_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BUSY && err && wr_en && wdata[7:0] == OP_CLR_STAT) |=> err);

   p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state == S_BUSY && rmode == RM_STATUS) |=> !rdata[7]);

   p_invalid_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (state == S_BUSY || state == S_SUSP) && rmode != RM_STATUS && part_hit)
      |=> (rdata == INV_WORD));

   p_suspend_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SUSP) |=> $stable(tick));

endmodule

bind fbp_cmd_seq fbp_cmd_seq_chk #(
   .DW          (DW),
   .AW          (AW),
   .BLK_AW      (BLK_AW),
   .PART_BITS   (PART_BITS),
   .BUF_WORDS   (BUF_WORDS),
   .PROG_CYCLES (PROG_CYCLES),
   .INV_WORD    (INV_WORD)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .rvalid (rvalid),
   .state  (state_q),
   .rmode  (rmode_q),
   .blk    (blk_q),
   .err    (err_q),
   .tick   (eng_tick)
);

// File: tb/sim_fbp_cmd_seq.sv
module sim_fbp_cmd_seq;

   localparam int DW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   always #10 clk = ~clk;   // 50 MHz

   fbp_cmd_seq u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata),
      .rvalid (rvalid)
   );

   typedef struct {
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int    nchk = 0;
   int    nerr = 0;
   bit    ended = 1'b0;

   task automatic chk(input string req, input logic [15:0] act,
                      input logic [15:0] exp, input string what);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   // monitor: pops expected read results in order
   initial begin
      forever begin
         item_t it;
         @(posedge clk);
         #5;
         if (rvalid && q.size() > 0) begin
            it = q.pop_front();
            chk(it.req, rdata, it.exp, "read");
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      wrap_up();
   end

   // driver tasks, called on a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
      item_t it;
      it.exp = exp; it.req = req;
      q.push_back(it);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic poll(output int zeros);
      zeros = 0;
      addr = '0; rd_en = 1'b1;
      for (int i = 0; i < 400; i++) begin
         @(posedge clk);
         #5;
         if (rdata[7]) break;
         zeros++;
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic prog(input logic [AW-1:0] start, input int n,
                       input logic [15:0] base, input bit peek);
      wr(start, 16'hE8);
      wr(start, 16'(n));
      for (int i = 0; i < n; i++) begin
         wr(AW'(start + i), base + 16'(i));
         if (peek && i == 2) rd(start, 16'h0080, "R5");
      end
      wr(start, 16'hD0);
   endtask

   initial begin
      int z;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, 16'h0080, "R1");
      wr(8'h00, 16'hFF);
      rd(8'h00, 16'hFFFF, "R1");
      rd(8'hC5, 16'hFFFF, "R1");
      wr(8'h00, 16'h70);

      // R11 read latency
      addr = '0; rd_en = 1'b1;
      @(posedge clk); #5;
      chk("R11", {15'b0, rvalid}, 16'd1, "rvalid after rd_en");
      @(negedge clk); rd_en = 1'b0;
      @(posedge clk); #5;
      chk("R11", {15'b0, rvalid}, 16'd0, "rvalid idle");
      @(negedge clk);

      // R2/R5/R6 aligned program with a read during fill
      prog(8'h20, 8, 16'h1000, 1'b1);
      poll(z);
      chk("R6", 16'(z), 16'd40, "aligned busy cycles");
      rd(8'h00, 16'h0080, "R6");
      wr(8'h00, 16'hFF);
      for (int i = 0; i < 8; i++) rd(AW'(8'h20 + i), 16'h1000 + 16'(i), "R2");

      // R6 crossing program
      prog(8'h1C, 8, 16'h2000, 1'b0);
      poll(z);
      chk("R6", 16'(z), 16'd80, "crossing busy cycles");
      wr(8'h00, 16'hFF);
      rd(8'h1C, 16'h2000, "R2");
      rd(8'h23, 16'h2007, "R2");
      rd(8'h24, 16'h1004, "R2");

      // R4 out-of-block abort
      wr(8'h40, 16'hE8);
      wr(8'h40, 16'd4);
      wr(8'h41, 16'h3333);
      wr(8'h80, 16'h4444);
      rd(8'h00, 16'h0090, "R4");
      wr(8'h40, 16'hFF);
      rd(8'h41, 16'hFFFF, "R4");

      // R7 error survives a later good program, then clears
      prog(8'h48, 2, 16'h3000, 1'b0);
      poll(z);
      chk("R6", 16'(z), 16'd40, "short aligned busy cycles");
      rd(8'h00, 16'h0090, "R7");
      wr(8'h00, 16'h50);
      rd(8'h00, 16'h0080, "R7");
      wr(8'h00, 16'hFF);
      rd(8'h49, 16'h3001, "R2");
      wr(8'h00, 16'h70);

      // R3 count limits and mismatch
      wr(8'h40, 16'hE8);
      wr(8'h40, 16'd33);
      rd(8'h00, 16'h0090, "R3");
      wr(8'h00, 16'h50);
      wr(8'h40, 16'hE8);
      wr(8'h40, 16'd0);
      rd(8'h00, 16'h0090, "R3");
      wr(8'h00, 16'h50);
      wr(8'h50, 16'hE8);
      wr(8'h50, 16'd2);
      wr(8'h50, 16'hAAAA);
      wr(8'h51, 16'hBBBB);
      wr(8'h52, 16'h1234);
      rd(8'h00, 16'h0090, "R3");
      wr(8'h00, 16'h50);
      wr(8'h00, 16'hFF);
      rd(8'h50, 16'hFFFF, "R3");
      prog(8'h80, 32, 16'h5000, 1'b0);
      poll(z);
      chk("R3", 16'(z), 16'd40, "full buffer busy cycles");
      rd(8'h00, 16'h0080, "R3");
      wr(8'h00, 16'hFF);
      rd(8'h80, 16'h5000, "R3");
      rd(8'h9F, 16'h501F, "R3");

      // R8/R9 busy filtering and invalid marker
      wr(8'h40, 16'hE8);
      wr(8'h40, 16'd0);
      prog(8'h00, 4, 16'h6000, 1'b0);
      wr(8'h00, 16'hFF);
      rd(8'h05, 16'hDEAD, "R9");
      rd(8'h85, 16'h5005, "R9");
      wr(8'h80, 16'h90);
      rd(8'h80, 16'h00A5, "R9");
      rd(8'h00, 16'hDEAD, "R9");
      wr(8'h80, 16'h98);
      rd(8'h90, 16'h0051, "R9");
      wr(8'h00, 16'h50);
      wr(8'h00, 16'h70);
      poll(z);
      rd(8'h00, 16'h0090, "R8");
      wr(8'h00, 16'h50);
      wr(8'h00, 16'hFF);
      rd(8'h00, 16'h6000, "R9");
      rd(8'h03, 16'h6003, "R9");

      // R10 suspend and resume
      prog(8'hC0, 4, 16'h7000, 1'b0);
      wr(8'hC0, 16'hB0);
      rd(8'h00, 16'h00C0, "R10");
      repeat (60) @(negedge clk);
      rd(8'h00, 16'h00C0, "R10");
      wr(8'hC0, 16'hD0);
      poll(z);
      chk("R10", 16'(z), 16'd39, "remaining busy cycles");
      wr(8'h00, 16'hFF);
      rd(8'hC0, 16'h7000, "R10");
      rd(8'hC3, 16'h7003, "R10");

      repeat (3) @(negedge clk);
      chk("R11", 16'(q.size()), 16'd0, "reads left unanswered");
      wrap_up();
   end

endmodule